// File: doc/BRIEF.md
# Dual-bank AES state store with permuted column reads

This block holds the 128-bit AES state for a 32-bit round datapath. The state is kept as four column words in two banks. While the datapath reads one bank it writes the other, and the two banks trade roles at the end of every round. A read does not return a stored column. It returns the word that the row-rotation step of the cipher would place in that column. Each of the four bytes is taken from a different stored column. In decrypt mode the rotations run the other way.

The S-box, column mixing and round-key logic sit outside the block. They appear only as a write-back port that returns one column word one cycle after the matching read. The first read of a new round needs one byte of the last column of the previous round, and that column is still being written in the same cycle. A single-byte bypass takes that byte straight from the write-back port, so rounds follow each other with no idle cycle. When the configured number of rounds has been written back, the finished block is presented on a result port.

Top module: `aes_colbank_pair`

## Requirements
- R1: A load cycle (`load_vld` high) writes `load_blk` into bank 0, latches `inv_mode` as the mode for the whole run, and restarts reading and writing at round 0, column 0. Byte n of the block occupies bits [127-8n -: 8]. Byte n sits in column n/4, row n%4. Column words hold row 0 in bits [31:24] down to row 3 in bits [7:0].
- R2: In encrypt mode (`inv_mode`=0), the read of column c returns, in row r, the byte at row r of stored column (c+r) mod 4. One round therefore reads {b0,b5,b10,b15}, {b4,b9,b14,b3}, {b8,b13,b2,b7} and {b12,b1,b6,b11}, in that order.
- R3: In decrypt mode, row r of the read of column c comes from stored column (c-r) mod 4. One round therefore reads {b0,b13,b10,b7}, {b4,b1,b14,b11}, {b8,b5,b2,b15} and {b12,b9,b6,b3}.
- R4: `rd_word` is combinational. The read column advances by one on each cycle with `rd_en` high, and on `rd_en` low the same word is held.
- R5: Each `wb_vld` cycle stores `wb_word` in the next column, counting 0 to 3, of the bank that is not being read. Round k reads bank k mod 2 and writes bank (k+1) mod 2.
- R6: When column 0 of a round is read in the same cycle that column 3 of that bank is written back, exactly one byte is bypassed from `wb_word`. In encrypt mode it is row 3 (bits [7:0]). In decrypt mode it is row 1 (bits [23:16]). The other bytes come from the bank.
- R7: Once NUM_ROUNDS rounds have been written back, `res_vld` is high and `res_blk` holds the final state in the byte layout of R1.
- R8: After completion, `rd_en` and `wb_vld` are ignored. `res_blk`, `res_vld` and `rd_word` hold until the next load.
- R9: During reset and in the first cycle after it, `rd_word` and `res_blk` read zero and `res_vld` is low.
- R10: A load during an unfinished run abandons that run. `res_vld` stays low until the new block's rounds are complete.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| load_vld | input | 1 | Load a new block and mode |
| load_blk | input | 128 | Input block, byte 0 in the top bits |
| inv_mode | input | 1 | 0 encrypt order, 1 decrypt order; sampled on load |
| rd_en | input | 1 | Advance to the next permuted column read |
| rd_word | output | 32 | Permuted column word for the current read |
| wb_vld | input | 1 | Write-back word valid |
| wb_word | input | 32 | Processed column word from the round logic |
| res_vld | output | 1 | All rounds written back |
| res_blk | output | 128 | Final state |

## Verification
On every cycle, the assertions check four things. The bypass never covers more than one lane. It fires only on a column-0 read, and only in the lane that the mode dictates. The read word holds while reads are paused. The result holds once the run is complete. Whether each permuted word carries the right bytes, and whether the bypassed byte matches what the bank would have held, can only be shown by the bench. The bench compares every read against a software model of the row rotation, across back-to-back rounds in both modes. It uses random read pauses, which move the bypass cycle around, and it includes an aborted run.

// File: rtl/cbk_pkg.sv
// Shared constants, types and index helper for the dual-bank state store.
// Assumes a 4x4 byte state, stored by columns.
package cbk_pkg;
    localparam int BYTE_W = 8;
    localparam int NROW   = 4;
    localparam int NCOL   = 4;
    localparam int WORD_W = BYTE_W * NROW;
    localparam int BLK_W  = WORD_W * NCOL;
    localparam int COL_W  = $clog2(NCOL);

    typedef logic [COL_W-1:0]  col_t;
    typedef logic [WORD_W-1:0] word_t;
    typedef logic [BLK_W-1:0]  blk_t;

    // Stored column that feeds row r of the permuted read of column c.
    function automatic col_t src_col(input col_t c, input int r, input logic inv);
        col_t rr;
        rr = col_t'(r);
        return inv ? col_t'(c - rr) : col_t'(c + rr);
    endfunction
endpackage

// File: rtl/cbk_bank.sv
// One state bank: four column registers plus a byte-gathering read port.
// Assumes at most one of load and write is active per cycle; load wins.
module cbk_bank
    import cbk_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  ld_en,
    input  blk_t  ld_blk,
    input  logic  wr_en,
    input  col_t  wr_col,
    input  word_t wr_word,
    input  col_t  rd_col,
    input  logic  inv,
    output word_t gat_word,
    output blk_t  contents
);
    word_t col_q [NCOL];

    // Column storage: cleared on reset, filled whole on load, one column per write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NCOL; i++) col_q[i] <= '0;
        end else if (ld_en) begin
            for (int i = 0; i < NCOL; i++)
                col_q[i] <= ld_blk[BLK_W-1-WORD_W*i -: WORD_W];
        end else if (wr_en) begin
            col_q[wr_col] <= wr_word;
        end
    end

    // Row r of the read word comes from a column rotated by r.
    for (genvar r = 0; r < NROW; r++) begin : g_lane
        col_t sc;
        assign sc = src_col(rd_col, r, inv);
        assign gat_word[WORD_W-1-BYTE_W*r -: BYTE_W] =
            col_q[sc][WORD_W-1-BYTE_W*r -: BYTE_W];
    end

    // Flattened contents, column 0 in the top bits.
    for (genvar c = 0; c < NCOL; c++) begin : g_flat
        assign contents[BLK_W-1-WORD_W*c -: WORD_W] = col_q[c];
    end
endmodule

// File: rtl/cbk_seq.sv
// Read and write column/round counters, bank selects and latched mode.
// Assumes the external round logic returns one write per read, one cycle later.
module cbk_seq
    import cbk_pkg::*;
#(
    parameter int NUM_ROUNDS = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic inv_in,
    input  logic rd_en,
    input  logic wb_vld,
    output col_t rd_col,
    output col_t wr_col,
    output logic rd_bank,
    output logic wr_bank,
    output logic mode,
    output logic rd_act,
    output logic wr_act,
    output logic done
);
    localparam int          RW       = $clog2(NUM_ROUNDS + 1);
    localparam logic [RW-1:0] LAST_RND = RW'(NUM_ROUNDS);
    localparam col_t        LAST_COL = col_t'(NCOL - 1);

    logic [RW-1:0] rd_rnd, wr_rnd;

    assign rd_act  = rd_en  & ~load & (rd_rnd != LAST_RND);
    assign wr_act  = wb_vld & ~load & (wr_rnd != LAST_RND);
    assign rd_bank = rd_rnd[0];
    assign wr_bank = ~wr_rnd[0];
    assign done    = (wr_rnd == LAST_RND);

    // Mode register: captured on every load.
    always_ff @(posedge clk) begin
        if (!rst_n)    mode <= 1'b0;
        else if (load) mode <= inv_in;
    end

    // Read position: column steps, round increments after the last column.
    always_ff @(posedge clk) begin
        if (!rst_n || load) begin
            rd_col <= '0;
            rd_rnd <= '0;
        end else if (rd_act) begin
            if (rd_col == LAST_COL) begin
                rd_col <= '0;
                rd_rnd <= rd_rnd + 1'b1;
            end else begin
                rd_col <= rd_col + 1'b1;
            end
        end
    end

    // Write position: same stepping, driven by write-back valid.
    always_ff @(posedge clk) begin
        if (!rst_n || load) begin
            wr_col <= '0;
            wr_rnd <= '0;
        end else if (wr_act) begin
            if (wr_col == LAST_COL) begin
                wr_col <= '0;
                wr_rnd <= wr_rnd + 1'b1;
            end else begin
                wr_col <= wr_col + 1'b1;
            end
        end
    end
endmodule

// File: rtl/cbk_fwd.sv
// Picks the read bank and bypasses any lane whose source column is being written.
// Assumes overlap only occurs for a column-0 read against a column-3 write.
module cbk_fwd
    import cbk_pkg::*;
(
    input  word_t            gat0,
    input  word_t            gat1,
    input  logic             rd_bank,
    input  logic             wr_bank,
    input  logic             wr_act,
    input  col_t             wr_col,
    input  col_t             rd_col,
    input  logic             mode,
    input  word_t            wb_word,
    output word_t            rd_word,
    output logic [NROW-1:0]  hit
);
    word_t sel;
    logic  same_bank;

    assign sel       = rd_bank ? gat1 : gat0;
    assign same_bank = wr_act & (wr_bank == rd_bank);

    // Per-lane bypass: source column equals the column under write.
    for (genvar r = 0; r < NROW; r++) begin : g_byp
        col_t sc;
        assign sc     = src_col(rd_col, r, mode);
        assign hit[r] = same_bank & (sc == wr_col);
        assign rd_word[WORD_W-1-BYTE_W*r -: BYTE_W] = hit[r]
            ? wb_word[WORD_W-1-BYTE_W*r -: BYTE_W]
            : sel[WORD_W-1-BYTE_W*r -: BYTE_W];
    end
endmodule

// File: rtl/aes_colbank_pair.sv
// Top: two column banks in ping-pong, permuted reads, one-byte bypass.
// Assumes NUM_ROUNDS >= 1; the result lands in bank NUM_ROUNDS mod 2.
module aes_colbank_pair
    import cbk_pkg::*;
#(
    parameter int NUM_ROUNDS = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_vld,
    input  logic [127:0] load_blk,
    input  logic         inv_mode,
    input  logic         rd_en,
    output logic [31:0]  rd_word,
    input  logic         wb_vld,
    input  logic [31:0]  wb_word,
    output logic         res_vld,
    output logic [127:0] res_blk
);
    localparam int NBANK    = 2;
    localparam int RES_BANK = NUM_ROUNDS % NBANK;

    col_t            rd_col, wr_col;
    logic            rd_bank, wr_bank, mode_q, rd_act, wr_act, done;
    word_t           gat [NBANK];
    blk_t            cont [NBANK];
    logic [NROW-1:0] fwd_hit;

    cbk_seq #(.NUM_ROUNDS(NUM_ROUNDS)) u_seq (
        .clk(clk), .rst_n(rst_n), .load(load_vld), .inv_in(inv_mode),
        .rd_en(rd_en), .wb_vld(wb_vld), .rd_col(rd_col), .wr_col(wr_col),
        .rd_bank(rd_bank), .wr_bank(wr_bank), .mode(mode_q),
        .rd_act(rd_act), .wr_act(wr_act), .done(done)
    );

    // Bank 0 takes the input block; bank 1 is only ever written back.
    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        logic ld_b, wr_b;
        assign ld_b = (b == 0) ? load_vld : 1'b0;
        assign wr_b = wr_act & (wr_bank == b[0]);
        cbk_bank u_bank (
            .clk(clk), .rst_n(rst_n), .ld_en(ld_b), .ld_blk(load_blk),
            .wr_en(wr_b), .wr_col(wr_col), .wr_word(wb_word),
            .rd_col(rd_col), .inv(mode_q), .gat_word(gat[b]), .contents(cont[b])
        );
    end

    cbk_fwd u_fwd (
        .gat0(gat[0]), .gat1(gat[1]), .rd_bank(rd_bank), .wr_bank(wr_bank),
        .wr_act(wr_act), .wr_col(wr_col), .rd_col(rd_col), .mode(mode_q),
        .wb_word(wb_word), .rd_word(rd_word), .hit(fwd_hit)
    );

    assign res_vld = done;
    assign res_blk = cont[RES_BANK];
endmodule

// File: rtl/cbk_chk.sv
// Property checker for aes_colbank_pair, attached by bind.
// Assumes the environment pairs each read with one write-back a cycle later.
module cbk_chk
    import cbk_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic            load_vld,
    input logic            rd_en,
    input logic [31:0]     rd_word,
    input logic            res_vld,
    input logic [127:0]    res_blk,
    input col_t            rd_col,
    input logic            mode,
    input logic [NROW-1:0] fwd_hit
);
    AST_FWD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(fwd_hit) <= 1); // R6
    AST_FWD_LANE: assert property (@(posedge clk) disable iff (!rst_n)
        (fwd_hit != '0) |-> (rd_col == '0 && fwd_hit == (mode ? 4'b0010 : 4'b1000))); // R6
    AST_READ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_en && !load_vld) |=> $stable(rd_word)); // R4
    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (res_vld && !load_vld) |=> (res_vld && $stable(res_blk))); // R8
    AST_LOAD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        load_vld |=> !res_vld); // R10
    AST_RESET_STATE: assert property (@(posedge clk)
        !rst_n |=> (!res_vld && rd_word == '0 && res_blk == '0)); // R9
endmodule

bind aes_colbank_pair cbk_chk u_chk (
    .clk(clk), .rst_n(rst_n), .load_vld(load_vld), .rd_en(rd_en),
    .rd_word(rd_word), .res_vld(res_vld), .res_blk(res_blk),
    .rd_col(rd_col), .mode(mode_q), .fwd_hit(fwd_hit)
);

// File: tb/test_aes_colbank_pair.sv
// Self-checking bench: random pauses and blocks against a software rotation model.
module test_aes_colbank_pair;
    localparam int NR   = 10;
    localparam int NRD  = 4 * NR;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         load_vld;
    logic [127:0] load_blk;
    logic         inv_mode;
    logic         rd_en;
    logic [31:0]  rd_word;
    logic         wb_vld;
    logic [31:0]  wb_word;
    logic         res_vld;
    logic [127:0] res_blk;

    int n_chk  = 0;
    int n_fail = 0;

    logic [31:0]  rdq [NRD];
    logic [31:0]  wbq [NRD];
    logic [127:0] fin;

    always #2 clk = ~clk;

    aes_colbank_pair #(.NUM_ROUNDS(NR)) i_aes_colbank_pair (
        .clk(clk), .rst_n(rst_n), .load_vld(load_vld), .load_blk(load_blk),
        .inv_mode(inv_mode), .rd_en(rd_en), .rd_word(rd_word),
        .wb_vld(wb_vld), .wb_word(wb_word), .res_vld(res_vld), .res_blk(res_blk)
    );

    task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Permuted read of column c: row r from column (c+r) or (c-r) mod 4.
    function automatic logic [31:0] gather(input logic [127:0] st, input int c, input bit inv);
        logic [31:0] w;
        for (int r = 0; r < 4; r++) begin
            int sc;
            sc = inv ? ((c - r + 4) % 4) : ((c + r) % 4);
            w[31-8*r -: 8] = st[127-8*(sc*4+r) -: 8];
        end
        return w;
    endfunction

    // Expected reads, write-back words and final state for one run.
    task automatic build(input logic [127:0] blk, input bit inv);
        logic [127:0] st, nst;
        st = blk;
        for (int k = 0; k < NR; k++) begin
            for (int c = 0; c < 4; c++) begin
                rdq[k*4+c] = gather(st, c, inv);
                wbq[k*4+c] = rdq[k*4+c] ^ $urandom();
                nst[127-32*c -: 32] = wbq[k*4+c];
            end
            st = nst;
        end
        fin = st;
    endtask

    task automatic do_load(input logic [127:0] blk, input bit inv);
        @(negedge clk);
        load_vld = 1'b1; load_blk = blk; inv_mode = inv;
        rd_en = 1'b0; wb_vld = 1'b0;
        @(negedge clk);
        load_vld = 1'b0; inv_mode = ~inv;
        #1;
        chk(rd_word == gather(blk, 0, inv), "R1", {96'd0, rd_word}, {96'd0, gather(blk, 0, inv)});
        chk(res_vld == 1'b0, "R1", {127'd0, res_vld}, 128'd0);
    endtask

    // Drive reads with random pauses and one-cycle-late write-backs.
    task automatic run(input bit inv, input int stall, input int nrd);
        bit          pend = 1'b0;
        logic [31:0] pd   = '0;
        int          j    = 0;
        while (j < nrd || pend) begin
            string tag;
            @(negedge clk);
            wb_vld  = pend;
            wb_word = pd;
            rd_en   = (j < nrd) && ($urandom_range(99) >= stall);
            #1;
            if (j < nrd) begin
                if (!rd_en)                          tag = "R4";
                else if (j % 4 == 0 && pend && j > 0) tag = "R6";
                else                                 tag = inv ? "R3" : "R2";
                chk(rd_word == rdq[j], tag, {96'd0, rd_word}, {96'd0, rdq[j]});
            end
            pend = rd_en;
            if (rd_en) begin
                pd = wbq[j];
                j++;
            end
        end
        @(negedge clk);
        rd_en = 1'b0; wb_vld = 1'b0;
        #1;
        if (nrd == NRD) begin
            chk(res_vld == 1'b1, "R7", {127'd0, res_vld}, 128'd1);
            chk(res_blk == fin, "R5_R7", res_blk, fin);
        end else begin
            chk(res_vld == 1'b0, "R10", {127'd0, res_vld}, 128'd0);
        end
    endtask

    initial begin
        #(4 * 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [127:0] blk, hold_blk;
        logic [31:0]  hold_word;
        bit           inv;
        void'($urandom(32'h5EED_0042));
        rst_n = 1'b0; load_vld = 1'b0; load_blk = '0; inv_mode = 1'b0;
        rd_en = 1'b0; wb_vld = 1'b0; wb_word = '0;
        repeat (3) @(posedge clk);
        @(negedge clk); #1;
        chk(rd_word == '0, "R9", {96'd0, rd_word}, 128'd0);
        chk(res_vld == 1'b0, "R9", {127'd0, res_vld}, 128'd0);
        chk(res_blk == '0, "R9", res_blk, 128'd0);
        rst_n = 1'b1;

        // Directed: counting bytes, no pauses, both orders.
        blk = 128'h000102030405060708090a0b0c0d0e0f;
        do_load(blk, 1'b0); build(blk, 1'b0); run(1'b0, 0, NRD);
        do_load(blk, 1'b1); build(blk, 1'b1); run(1'b1, 0, NRD);

        // Random blocks, modes and pauses.
        for (int it = 0; it < 6; it++) begin
            blk = {$urandom(), $urandom(), $urandom(), $urandom()};
            inv = 1'($urandom_range(1));
            do_load(blk, inv); build(blk, inv); run(inv, 35, NRD);
        end

        // R8: after completion reads and write-backs have no effect.
        hold_blk = res_blk; hold_word = rd_word;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            rd_en = 1'b1; wb_vld = 1'b1; wb_word = $urandom();
        end
        @(negedge clk);
        rd_en = 1'b0; wb_vld = 1'b0;
        #1;
        chk(res_blk == hold_blk, "R8", res_blk, hold_blk);
        chk(res_vld == 1'b1, "R8", {127'd0, res_vld}, 128'd1);
        chk(rd_word == hold_word, "R8", {96'd0, rd_word}, {96'd0, hold_word});

        // R10: abandon a run part way, then a full run on a new block.
        blk = {$urandom(), $urandom(), $urandom(), $urandom()};
        do_load(blk, 1'b0); build(blk, 1'b0); run(1'b0, 20, 9);
        blk = {$urandom(), $urandom(), $urandom(), $urandom()};
        do_load(blk, 1'b1); build(blk, 1'b1); run(1'b1, 20, NRD);

        $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule